// File: doc/BRIEF.md
# Dual-Mode Processor Counter-Timer Bank

This block holds one counter-timer per processor plus a small system window. Each processor timer runs in one of two modes. In counter mode it counts ticks up to a programmable limit. When it reaches the limit it wraps to zero, sets a reached flag and raises its interrupt. A limit of zero makes it count freely with no interrupt.

In user mode the same storage becomes a 64-bit running count. Software loads it as two 32-bit words and reads it back the same way. Software starts and stops it through a status bit, and it never interrupts.

A mode bitmask in the system window picks the mode of each processor. A change of a mode bit stops or restarts that processor's timer as defined below.

Software reaches all windows through one word-addressed 32-bit register port. `busSel` is 0 for the system window and i+1 for processor i, and `busAddr` is the word offset. A shared prescaler makes one tick every `TICK_CYCLES` clocks. One tick adds 0x200 to the visible count, so the low 9 bits of every count word read as zero.

Top module: `cpu_timer_bank`

## Requirements
- R1: After reset, every mode bit is 0 and every timer is in free-running counter mode. Its status reads 1, its limit reads 0 and its interrupt is low.
- R2: System window offset 4 holds the mode bitmask. Bit i set puts processor i in user mode. Bits at and above `NUM_CPU` read 0 and ignore writes. A write to offset 4 of a processor window does not change the mask, and that offset reads 0 there.
- R3: In counter mode, writing offset 0 sets the limit from bits 30:9 and clears the count. Writing offset 2 sets the limit and leaves the count running. Reading offset 0 returns the limit in bits 30:9 and clears the reached flag and the interrupt. Reading offset 1 returns the reached flag in bit 31 and the count in bits 30:9.
- R4: In counter mode with a nonzero limit, the tick that would bring the count to the limit instead zeroes it and sets both the reached flag and the interrupt. With a limit of 0 the count wraps freely and raises no interrupt.
- R5: In user mode, offset 0 reads the reached flag in bit 31 and bits 62:32 of the 64-bit count in bits 30:0. Offset 1 reads count bits 31:0, with bits 8:0 always zero.
- R6: In user mode, a write to offset 0 loads count bits 62:32 from write bits 30:0 and drops write bit 31. A write to offset 1 loads count bits 31:9 from the same write bits. Either write clears the reached flag, and counting resumes from the loaded value.
- R7: Writing status (offset 3) bit 0 in user mode starts the timer with 1 and stops it with 0. Status reads the running bit in bit 0. Status writes are ignored in counter mode. System window status reads 0.
- R8: A running user timer adds 0x200 per tick. A stopped one holds its value.
- R9: A user count stops at 0x7FFFFFFFFFFFFE00 and sets the reached flag on the tick that arrives there.
- R10: A processor in user mode never raises its interrupt.
- R11: Changing a mode bit from 0 to 1 lowers that processor's interrupt, stops its timer, clears its running bit and reached flag, and drops its counter limit. Offset 0 then reads 0 after a return to counter mode.
- R12: Changing a mode bit from 1 to 0 stops the user count and restarts the timer in counter mode with running set. A write that leaves a mode bit unchanged has no effect on that processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busSel | input | $clog2(NUM_CPU+1) | Window select: 0 system, i+1 processor i |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read strobe, one cycle (reads can clear state) |
| busAddr | input | 3 | Word offset inside the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the current state |
| irq | output | NUM_CPU | Per-processor interrupt, level |

## Verification
The bench first aims at the mode-switch edges. It raises an interrupt and then flips that processor to user mode. A design that forgot to lower the interrupt or to stop the count would show a live `irq` or a moving low word.

It loads a user count two ticks below the ceiling and lets it run well past that point. A counter that wrapped, or that failed to flag the ceiling, would read back something other than all ones in the upper word.

It also rewrites a mode bit with its current value, writes the mode register through a processor window, and writes status in counter mode. A design that acted on any of these would show a stopped timer or a changed mask.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int WORD_W = 32;
  localparam int USER_TICK_W = 54;   // count bits 62:9 in tick units
  localparam int CTR_TICK_W = 22;    // count bits 30:9 in tick units
  localparam int LOW_SHIFT = 9;

  typedef struct packed {
    logic tick;
    logic ldHigh;
    logic ldLow;
    logic ldLimRst;
    logic ldLimKeep;
    logic rdClr;
    logic runSet;
    logic runClr;
    logic toUser;
    logic toCounter;
  } tmrStb_t;
endpackage

// File: rtl/ctb_ctrl.sv
module ctb_ctrl
  import ctb_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int TICK_CYCLES = 4,
  localparam int SEL_W = $clog2(NUM_CPU + 1),
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        busSel,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [2:0]              busAddr,
  input  logic [NUM_CPU-1:0]      modeWdata,
  input  logic [USER_TICK_W-1:0]  cntIn [NUM_CPU],
  input  logic [CTR_TICK_W-1:0]   limIn [NUM_CPU],
  input  logic [NUM_CPU-1:0]      reachIn,
  input  logic [NUM_CPU-1:0]      runIn,
  output tmrStb_t                 stbOut [NUM_CPU],
  output logic [NUM_CPU-1:0]      userMode,
  output logic [WORD_W-1:0]       busRdata
);
  logic [PRE_W-1:0] preCnt;
  logic tick;
  logic sysHit;
  logic modeWr;

  assign tick = (preCnt == PRE_W'(TICK_CYCLES - 1));
  assign sysHit = (busSel == '0);
  assign modeWr = busWr && sysHit && (busAddr == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      userMode <= '0;
    end else if (modeWr) begin
      userMode <= modeWdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      logic hit;
      logic pw;
      logic pr;
      hit = (busSel == SEL_W'(i + 1));
      pw = busWr && hit;
      pr = busRd && hit;
      stbOut[i].tick      = tick;
      stbOut[i].ldHigh    = pw && userMode[i] && (busAddr == 3'd0);
      stbOut[i].ldLow     = pw && userMode[i] && (busAddr == 3'd1);
      stbOut[i].ldLimRst  = pw && !userMode[i] && (busAddr == 3'd0);
      stbOut[i].ldLimKeep = pw && !userMode[i] && (busAddr == 3'd2);
      stbOut[i].rdClr     = pr && !userMode[i] && (busAddr == 3'd0);
      stbOut[i].runSet    = pw && userMode[i] && (busAddr == 3'd3) && modeWdata[0];
      stbOut[i].runClr    = pw && userMode[i] && (busAddr == 3'd3) && !modeWdata[0];
      stbOut[i].toUser    = modeWr && modeWdata[i] && !userMode[i];
      stbOut[i].toCounter = modeWr && !modeWdata[i] && userMode[i];
    end
  end

  always_comb begin
    busRdata = '0;
    if (sysHit) begin
      if (busAddr == 3'd4) busRdata = WORD_W'(userMode);
    end else begin
      for (int i = 0; i < NUM_CPU; i++) begin
        if (busSel == SEL_W'(i + 1)) begin
          case (busAddr)
            3'd0: busRdata = userMode[i] ? {reachIn[i], cntIn[i][53:23]}
                                         : {1'b0, limIn[i], 9'b0};
            3'd1: busRdata = userMode[i] ? {cntIn[i][22:0], 9'b0}
                                         : {reachIn[i], cntIn[i][21:0], 9'b0};
            3'd3: busRdata = {31'b0, runIn[i]};
            default: busRdata = '0;
          endcase
        end
      end
    end
  end

  // R2: a system-window write to offset 4 lands in the mask
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    modeWr |=> (userMode == $past(modeWdata)));
  // R2: nothing else moves the mask
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !modeWr |=> $stable(userMode));
endmodule

// File: rtl/ctb_timer_dp.sv
module ctb_timer_dp
  import ctb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  tmrStb_t                 stb,
  input  logic [WORD_W-1:0]       wdata,
  input  logic                    userMode,
  output logic [USER_TICK_W-1:0]  cnt,
  output logic [CTR_TICK_W-1:0]   limit,
  output logic                    reached,
  output logic                    running,
  output logic                    irq
);
  localparam logic [USER_TICK_W-1:0] CEIL = '1;

  logic [CTR_TICK_W-1:0] nxtLow;
  logic limitHit;
  logic atCeil;

  assign nxtLow = cnt[CTR_TICK_W-1:0] + CTR_TICK_W'(1);
  assign limitHit = (limit != '0) && (nxtLow == limit);
  assign atCeil = (cnt == CEIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      limit <= '0;
      reached <= 1'b0;
      running <= 1'b1;
      irq <= 1'b0;
    end else if (stb.toUser) begin
      irq <= 1'b0;
      running <= 1'b0;
      reached <= 1'b0;
      limit <= '0;
    end else if (stb.toCounter) begin
      running <= 1'b1;
      reached <= 1'b0;
      cnt <= {{(USER_TICK_W-CTR_TICK_W){1'b0}}, cnt[CTR_TICK_W-1:0]};
    end else if (userMode) begin
      if (stb.ldHigh) begin
        cnt[53:23] <= wdata[30:0];
        reached <= 1'b0;
      end else if (stb.ldLow) begin
        cnt[22:0] <= wdata[31:9];
        reached <= 1'b0;
      end else if (stb.tick && running && !atCeil) begin
        cnt <= cnt + USER_TICK_W'(1);
        if (cnt == CEIL - USER_TICK_W'(1)) reached <= 1'b1;
      end
      if (stb.runSet) running <= 1'b1;
      else if (stb.runClr) running <= 1'b0;
    end else begin
      if (stb.ldLimRst || stb.ldLimKeep) limit <= wdata[30:9];
      if (stb.rdClr) begin
        reached <= 1'b0;
        irq <= 1'b0;
      end
      if (stb.ldLimRst) begin
        cnt <= '0;
        irq <= 1'b0;
      end else if (stb.tick) begin
        if (limitHit) begin
          cnt <= '0;
          reached <= 1'b1;
          irq <= 1'b1;
        end else begin
          cnt <= {{(USER_TICK_W-CTR_TICK_W){1'b0}}, nxtLow};
        end
      end
    end
  end

  // R10: user mode keeps the interrupt low
  a_r10_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    userMode |-> !irq);
  // R11: entering user mode stops and silences the timer
  a_r11_enter_user: assert property (@(posedge clk) disable iff (!rst_n)
    stb.toUser |=> (!running && !irq && limit == '0));
  // R12: counter mode always runs
  a_r12_counter_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !userMode |-> running);
  // R8: a stopped user count holds unless software loads it
  a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (userMode && !running && !stb.ldHigh && !stb.ldLow && !stb.toCounter)
      |=> $stable(cnt));
  // R9: in user mode the reached flag only rises at the ceiling
  a_r9_ceiling_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (userMode && $past(userMode) && $rose(reached)) |-> atCeil);
endmodule

// File: rtl/cpu_timer_bank.sv
module cpu_timer_bank
  import ctb_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int TICK_CYCLES = 4,
  localparam int SEL_W = $clog2(NUM_CPU + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   busSel,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [2:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_CPU-1:0] irq
);
  tmrStb_t stb [NUM_CPU];
  logic [USER_TICK_W-1:0] cntA [NUM_CPU];
  logic [CTR_TICK_W-1:0] limA [NUM_CPU];
  logic [NUM_CPU-1:0] reachA;
  logic [NUM_CPU-1:0] runA;
  logic [NUM_CPU-1:0] userMode;

  ctb_ctrl #(.NUM_CPU(NUM_CPU), .TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .modeWdata(busWdata[NUM_CPU-1:0]),
    .cntIn(cntA), .limIn(limA), .reachIn(reachA), .runIn(runA),
    .stbOut(stb), .userMode(userMode), .busRdata(busRdata)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_unit
    ctb_timer_dp u_dp (
      .clk(clk), .rst_n(rst_n), .stb(stb[g]), .wdata(busWdata),
      .userMode(userMode[g]), .cnt(cntA[g]), .limit(limA[g]),
      .reached(reachA[g]), .running(runA[g]), .irq(irq[g])
    );
  end
endmodule

// File: tb/sim_cpu_timer_bank.sv
module sim_cpu_timer_bank;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] busSel = '0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] irq;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cpu_timer_bank #(.NUM_CPU(N), .TICK_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = sel; busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = sel; busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 4, v); check("R1 mode", v, 0);
    for (int i = 1; i <= N; i++) begin
      rd(3'(i), 3, v); check("R1 status", v, 1);
    end
    rd(1, 0, v); check("R1 limit", v, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_mode_reg();
    logic [31:0] v;
    wr(0, 4, 32'hFFFF_FFFF);
    rd(0, 4, v); check("R2 upper bits", v, 32'hF);
    wr(2, 4, 32'h0);
    rd(0, 4, v); check("R2 cpu window write", v, 32'hF);
    rd(2, 4, v); check("R2 cpu window read", v, 0);
    wr(0, 4, 32'h0);
    rd(0, 4, v); check("R2 clear", v, 0);
    rd(0, 3, v); check("R7 sys status", v, 0);
  endtask

  task automatic t_counter_irq();
    logic [31:0] v;
    wr(2, 0, 32'h0000_0A00);
    idle(10); check("R4 early", 32'(irq[1]), 0);
    idle(20); check("R4 fired", 32'(irq[1]), 1);
    rd(2, 1, v); check("R3 reached bit", 32'(v[31]), 1);
    rd(2, 0, v); check("R3 limit read", v, 32'h0000_0A00);
    check("R3 read clears irq", 32'(irq[1]), 0);
    wr(2, 2, 32'h0);
    rd(2, 0, v); check("R3 keep-limit write", v, 0);
    idle(120); check("R4 free-run no irq", 32'(irq[1]), 0);
    wr(3, 3, 32'h0);
    rd(3, 3, v); check("R7 counter status ignored", v, 1);
  endtask

  task automatic t_user();
    logic [31:0] v, a, b;
    wr(1, 0, 32'h0000_0600);
    idle(20); check("R4 cpu0 irq", 32'(irq[0]), 1);
    wr(0, 4, 32'h1);
    check("R11 irq lowered", 32'(irq[0]), 0);
    rd(1, 3, v); check("R11 stopped", v, 0);
    rd(1, 1, a); idle(20); rd(1, 1, b); check("R8 stopped holds", b, a);
    wr(1, 0, 32'h9234_5678);
    wr(1, 1, 32'hABCD_EFFF);
    rd(1, 0, v); check("R6 upper masked", v, 32'h1234_5678);
    rd(1, 1, v); check("R5 lower layout", v, 32'hABCD_EE00);
    wr(1, 3, 32'h1);
    rd(1, 3, v); check("R7 started", v, 1);
    idle(40);
    wr(1, 3, 32'h0);
    rd(1, 3, v); check("R7 stopped", v, 0);
    rd(1, 1, a);
    b = a - 32'hABCD_EE00;
    total++;
    if (b[8:0] != 0 || b < 32'h1200 || b > 32'h1800) begin
      bad++;
      $display("FAIL R8 delta got=%h exp=1200..1800", b);
    end
    rd(1, 0, v); check("R8 upper unchanged", v, 32'h1234_5678);
    wr(1, 0, 32'h7FFF_FFFF);
    wr(1, 1, 32'hFFFF_FA00);
    wr(1, 3, 32'h1);
    idle(40);
    rd(1, 0, v); check("R9 reached+upper", v, 32'hFFFF_FFFF);
    rd(1, 1, v); check("R9 saturated lower", v, 32'hFFFF_FE00);
    check("R10 no irq", 32'(irq[0]), 0);
    wr(1, 1, 32'h0);
    rd(1, 0, v); check("R6 load clears reached", v, 32'h7FFF_FFFF);
    wr(0, 4, 32'h1);
    rd(1, 3, v); check("R12 same bit no effect", v, 1);
    wr(0, 4, 32'h0);
    rd(1, 3, v); check("R12 back to counter", v, 1);
    rd(1, 0, v); check("R11 limit dropped", v, 0);
    rd(1, 1, a); idle(20); rd(1, 1, b);
    total++;
    if (a == b) begin
      bad++;
      $display("FAIL R12 counting got=%h exp!=%h", b, a);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_reg();
    t_counter_irq();
    t_user();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule